// File: doc/BRIEF.md
# Texture Handle Table Walker

The walker turns a constant buffer full of packed texture handles into a stream of descriptor fetch addresses. Software first binds a buffer (enable, base address and byte size) to each shader stage. A start pulse then selects one stage. The walker reads that stage's buffer one 32-bit word at a time through a simple request/response read port. The first handle sits 32 bytes past the buffer base.

Each handle carries an image id and a sampler id. For every handle with a nonzero image id, the walker emits one record on a valid/ready output. The record holds the texture's slot index, the image descriptor address and, when the sampler id is nonzero, the sampler descriptor address. The descriptor contents are left to the consumer. When the read pointer reaches the end of the buffer, the walker pulses `done` and returns to idle. A start that names an unusable buffer is refused with an `err` pulse.

Top module: `tex_handle_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `rdReq`, `recValid`, `done` and `err` are all low.
- R2: A scan reads byte addresses base+32, base+36, base+40 and so on, in rising order. It issues one `rdReq` per handle, and never issues a second request before the previous `rdValid` has come back.
- R3: The scan ends once the read address is at or beyond base+size, so no read is made when size ≤ 32. `done` is then high for exactly one cycle and the walker goes idle.
- R4: A record's `recIndex` equals (read address − base − 32) / 4.
- R5: The image id is handle bits [19:0]. A record is emitted if and only if this id is nonzero. Handles with a zero image id are skipped silently.
- R6: `recImgAddr` = `imgBase` + image id × 32.
- R7: The sampler id is handle bits [31:20]. When it is nonzero, `recSmpValid` is 1 and `recSmpAddr` = `smpBase` + sampler id × 32. When it is zero, `recSmpValid` is 0 and `recSmpAddr` is 0.
- R8: A start is refused if the selected stage is disabled, if its address is zero, or if `stageSel` ≥ the number of stages. On a refused start, `err` pulses for one cycle, on the cycle after start. No read is made and `busy` stays low.
- R9: While `recValid` is high and `recReady` is low, the record is held with all of its fields unchanged.
- R10: A start pulse while `busy` is high is ignored. The running scan continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan of the selected stage |
| stageSel | input | STAGE_W | Stage whose buffer is scanned |
| stageEn | input | NUM_STAGES | Per-stage buffer enable |
| stageAddr | input | NUM_STAGES*AW | Per-stage buffer base address, stage i in slice i |
| stageSize | input | NUM_STAGES*SIZE_W | Per-stage buffer size in bytes |
| imgBase | input | AW | Image descriptor table base |
| smpBase | input | AW | Sampler descriptor table base |
| rdReq | output | 1 | Read request, one cycle |
| rdAddr | output | AW | Read byte address |
| rdValid | input | 1 | Read data is present |
| rdData | input | 32 | Read data (one handle) |
| recValid | output | 1 | Record valid |
| recReady | input | 1 | Consumer accepts the record |
| recIndex | output | AW | Texture slot index |
| recImgAddr | output | AW | Image descriptor address |
| recSmpAddr | output | AW | Sampler descriptor address |
| recSmpValid | output | 1 | Sampler address is meaningful |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, one-cycle pulse |
| err | output | 1 | Start refused, one-cycle pulse |

## Verification
The assertions rest on four assumptions about the inputs:
- `rdValid` comes only as a single-cycle answer to an outstanding request.
- The stage buffer inputs and both table bases stay still while a scan runs.
- base+size does not wrap the address space.
- Base addresses are word aligned.

The stimulus keeps to these assumptions. Its memory model answers each request once, after one to four cycles. Configuration changes only between scans. Bases are multiples of 4 placed well below the top of the address range. Buffer sizes are swept over empty, sub-offset, odd-sized and multi-handle cases on every stage.

// File: rtl/tex_walk_pkg.sv
package tex_walk_pkg;
  localparam int HANDLE_W     = 32;
  localparam int HANDLE_SHIFT = 2;   // 4-byte handles
  localparam int INFO_OFFSET  = 32;  // first handle offset in the buffer
  localparam int DESC_SHIFT   = 5;   // 32-byte descriptors
  localparam int IMG_ID_W     = 20;
  localparam int SMP_ID_W     = HANDLE_W - IMG_ID_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_EMIT
  } walkState_t;

  typedef struct packed {
    logic load;     // capture buffer window, point at first handle
    logic latch;    // capture returned handle
    logic advance;  // step to the next handle
  } walkCtl_t;
endpackage

// File: rtl/tex_walk_ctrl.sv
module tex_walk_ctrl
  import tex_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     startOk,
  input  logic     atEnd,
  input  logic     rdValid,
  input  logic     dataImgLive,
  input  logic     recReady,
  output walkCtl_t ctl,
  output logic     rdReq,
  output logic     recValid,
  output logic     busy,
  output logic     done,
  output logic     err
);
  walkState_t state, nextState;
  logic errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nextState;
      errQ  <= (state == ST_IDLE) && start && !startOk;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    rdReq     = 1'b0;
    recValid  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: if (start && startOk) begin
        ctl.load  = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (atEnd) begin
          done      = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_REQ;
        end
      end
      ST_REQ: begin
        rdReq     = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (rdValid) begin
        ctl.latch = 1'b1;
        if (dataImgLive) begin
          nextState = ST_EMIT;
        end else begin
          ctl.advance = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_EMIT: begin
        recValid = 1'b1;
        if (recReady) begin
          ctl.advance = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign err  = errQ;

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);
  // R9
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy && !rdReq);
endmodule

// File: rtl/tex_walk_dp.sv
module tex_walk_dp
  import tex_walk_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkCtl_t            ctl,
  input  logic [AW-1:0]       selAddr,
  input  logic [SIZE_W-1:0]   selSize,
  input  logic [HANDLE_W-1:0] rdData,
  input  logic [AW-1:0]       imgBase,
  input  logic [AW-1:0]       smpBase,
  output logic [AW-1:0]       rdAddr,
  output logic                atEnd,
  output logic                dataImgLive,
  output logic [AW-1:0]       recIndex,
  output logic [AW-1:0]       recImgAddr,
  output logic [AW-1:0]       recSmpAddr,
  output logic                recSmpValid
);
  logic [AW-1:0]       curAddr, endAddr, bufAddr, offs;
  logic [HANDLE_W-1:0] handleQ;
  logic [IMG_ID_W-1:0] imgId;
  logic [SMP_ID_W-1:0] smpId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      endAddr <= '0;
      bufAddr <= '0;
      handleQ <= '0;
    end else begin
      if (ctl.load) begin
        bufAddr <= selAddr;
        curAddr <= selAddr + AW'(INFO_OFFSET);
        endAddr <= selAddr + AW'(selSize);
      end else if (ctl.advance) begin
        curAddr <= curAddr + AW'(1 << HANDLE_SHIFT);
      end
      if (ctl.latch) handleQ <= rdData;
    end
  end

  assign imgId       = handleQ[IMG_ID_W-1:0];
  assign smpId       = handleQ[HANDLE_W-1:IMG_ID_W];
  assign rdAddr      = curAddr;
  assign atEnd       = (curAddr >= endAddr);
  assign dataImgLive = (rdData[IMG_ID_W-1:0] != '0);
  assign offs        = curAddr - bufAddr - AW'(INFO_OFFSET);
  assign recIndex    = offs >> HANDLE_SHIFT;
  assign recImgAddr  = imgBase + (AW'(imgId) << DESC_SHIFT);
  assign recSmpValid = (smpId != '0);
  assign recSmpAddr  = recSmpValid ? smpBase + (AW'(smpId) << DESC_SHIFT) : '0;
endmodule

// File: rtl/tex_handle_walker.sv
module tex_handle_walker
  import tex_walk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SIZE_W     = 16,
  parameter int NUM_STAGES = 5,
  parameter int STAGE_W    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [STAGE_W-1:0]           stageSel,
  input  logic [NUM_STAGES-1:0]        stageEn,
  input  logic [NUM_STAGES*AW-1:0]     stageAddr,
  input  logic [NUM_STAGES*SIZE_W-1:0] stageSize,
  input  logic [AW-1:0]                imgBase,
  input  logic [AW-1:0]                smpBase,
  output logic                         rdReq,
  output logic [AW-1:0]                rdAddr,
  input  logic                         rdValid,
  input  logic [31:0]                  rdData,
  output logic                         recValid,
  input  logic                         recReady,
  output logic [AW-1:0]                recIndex,
  output logic [AW-1:0]                recImgAddr,
  output logic [AW-1:0]                recSmpAddr,
  output logic                         recSmpValid,
  output logic                         busy,
  output logic                         done,
  output logic                         err
);
  logic [AW-1:0]     addrArr [NUM_STAGES];
  logic [SIZE_W-1:0] sizeArr [NUM_STAGES];
  logic [AW-1:0]     selAddr;
  logic [SIZE_W-1:0] selSize;
  logic              selEn, startOk, atEnd, dataImgLive;
  walkCtl_t          ctl;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign addrArr[s] = stageAddr[s*AW +: AW];
    assign sizeArr[s] = stageSize[s*SIZE_W +: SIZE_W];
  end

  always_comb begin
    selAddr = '0;
    selSize = '0;
    selEn   = 1'b0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (stageSel == STAGE_W'(s)) begin
        selAddr = addrArr[s];
        selSize = sizeArr[s];
        selEn   = stageEn[s];
      end
    end
  end

  assign startOk = selEn && (selAddr != '0);

  tex_walk_ctrl u_ctrl (
    .clk, .rstN, .start, .startOk, .atEnd, .rdValid, .dataImgLive,
    .recReady, .ctl, .rdReq, .recValid, .busy, .done, .err
  );

  tex_walk_dp #(.AW(AW), .SIZE_W(SIZE_W)) u_dp (
    .clk, .rstN, .ctl, .selAddr, .selSize, .rdData, .imgBase, .smpBase,
    .rdAddr, .atEnd, .dataImgLive, .recIndex, .recImgAddr, .recSmpAddr,
    .recSmpValid
  );

  // R9
  stable_rec_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> $stable(recIndex) && $stable(recImgAddr)
                              && $stable(recSmpAddr) && $stable(recSmpValid));
endmodule

// File: tb/tb_tex_handle_walker.sv
module tb_tex_handle_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, SIZE_W = 16, NS = 5, SW = 3;

  logic clk = 0, rstN = 0, start = 0;
  logic [SW-1:0] stageSel = '0;
  logic [NS-1:0] stageEn = '0;
  logic [NS*AW-1:0] stageAddr = '0;
  logic [NS*SIZE_W-1:0] stageSize = '0;
  logic [AW-1:0] imgBase = 32'h0010_0000, smpBase = 32'h0200_0040;
  logic rdReq, rdValid = 0, recValid, recReady = 0, recSmpValid, busy, done, err;
  logic [AW-1:0] rdAddr, recIndex, recImgAddr, recSmpAddr;
  logic [31:0] rdData = '0;

  int checks = 0, fails = 0;
  int expRd[64], nExpRd, rdCnt;
  logic [AW-1:0] eIdx[64], eImg[64], eSmp[64];
  logic eSv[64];
  int nExpRec, recCnt, cyc = 0;
  logic held = 0;
  logic [AW-1:0] hIdx, hImg, hSmp;

  tex_handle_walker #(.AW(AW), .SIZE_W(SIZE_W), .NUM_STAGES(NS), .STAGE_W(SW)) dut (
    .clk, .rstN, .start, .stageSel, .stageEn, .stageAddr, .stageSize, .imgBase,
    .smpBase, .rdReq, .rdAddr, .rdValid, .rdData, .recValid, .recReady, .recIndex,
    .recImgAddr, .recSmpAddr, .recSmpValid, .busy, .done, .err
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [19:0] img;
    logic [11:0] smp;
    img = ((a >> 2) % 3 == 0) ? 20'h0 : 20'(((a >> 2) ^ 32'h13));
    smp = ((a >> 2) % 2 == 0) ? 12'h0 : 12'((a >> 4) + 1);
    return {smp, img};
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", req, msg); end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rdReq) begin
        logic [31:0] a;
        a = rdAddr;
        repeat (1 + int'(a[3:2])) @(negedge clk);
        rdData = memWord(a); rdValid = 1;
        @(negedge clk);
        rdValid = 0;
      end
    end
  end

  // monitor and ready pattern
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      recReady = (cyc % 3) != 1;
      if (rdReq) begin
        if (rdCnt < nExpRd)
          check(rdAddr == expRd[rdCnt], "R2",
                $sformatf("read addr act %h exp %h", rdAddr, expRd[rdCnt]));
        else check(0, "R3", $sformatf("extra read at %h exp none", rdAddr));
        rdCnt++;
      end
      if (held) begin
        check(recValid && recIndex == hIdx && recImgAddr == hImg && recSmpAddr == hSmp, "R9",
              $sformatf("held rec act %0d/%h/%h exp %0d/%h/%h",
                        recIndex, recImgAddr, recSmpAddr, hIdx, hImg, hSmp));
        held = 0;
      end
      if (recValid && !recReady) begin
        held = 1; hIdx = recIndex; hImg = recImgAddr; hSmp = recSmpAddr;
      end
      if (recValid && recReady) begin
        if (recCnt < nExpRec) begin
          // R4 R5 R6 R7
          check(recIndex == eIdx[recCnt] && recImgAddr == eImg[recCnt] &&
                recSmpValid == eSv[recCnt] && recSmpAddr == eSmp[recCnt], "R4/R5/R6/R7",
                $sformatf("rec act %0d %h %b %h exp %0d %h %b %h", recIndex, recImgAddr,
                          recSmpValid, recSmpAddr, eIdx[recCnt], eImg[recCnt],
                          eSv[recCnt], eSmp[recCnt]));
        end else check(0, "R5", $sformatf("extra rec idx %0d exp none", recIndex));
        recCnt++;
      end
    end
  end

  task automatic runScan(input int sel, input logic [31:0] base, input int size, input bit restart);
    stageSel = SW'(sel);
    stageEn[sel] = 1'b1;
    stageAddr[sel*AW +: AW] = base;
    stageSize[sel*SIZE_W +: SIZE_W] = SIZE_W'(size);
    nExpRd = 0; nExpRec = 0; rdCnt = 0; recCnt = 0;
    for (logic [31:0] a = base + 32; a < base + 32'(size); a += 4) begin
      logic [31:0] w;
      w = memWord(a);
      expRd[nExpRd++] = int'(a);
      if (w[19:0] != 0) begin
        eIdx[nExpRec] = (a - base - 32) >> 2;
        eImg[nExpRec] = imgBase + ({12'h0, w[19:0]} << 5);
        eSv[nExpRec]  = (w[31:20] != 0);
        eSmp[nExpRec] = (w[31:20] != 0) ? smpBase + ({20'h0, w[31:20]} << 5) : 0;
        nExpRec++;
      end
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (restart) begin
      repeat (3) @(negedge clk);
      check(busy, "R10", $sformatf("busy act %b exp 1", busy));
      stageSel = SW'((sel + 1) % NS); start = 1;
      @(negedge clk); start = 0; stageSel = SW'(sel);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done && !busy, "R3", $sformatf("done/busy act %b%b exp 00", done, busy));
    check(rdCnt == nExpRd, "R2", $sformatf("reads act %0d exp %0d", rdCnt, nExpRd));
    check(recCnt == nExpRec, "R5", $sformatf("records act %0d exp %0d", recCnt, nExpRec));
  endtask

  task automatic refused(input int sel, input bit en, input logic [31:0] base);
    int reqs = 0;
    stageSel = SW'(sel);
    if (sel < NS) begin
      stageEn[sel] = en;
      stageAddr[sel*AW +: AW] = base;
      stageSize[sel*SIZE_W +: SIZE_W] = 16'h40;
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(err && !busy, "R8", $sformatf("err/busy act %b%b exp 10", err, busy));
    @(negedge clk);
    check(!err, "R8", $sformatf("err second cycle act %b exp 0", err));
    repeat (4) begin if (rdReq || busy) reqs++; @(negedge clk); end
    check(reqs == 0, "R8", $sformatf("activity act %0d exp 0", reqs));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busy && !rdReq && !recValid && !done && !err, "R1",
          $sformatf("reset outs act %b%b%b%b%b exp 00000", busy, rdReq, recValid, done, err));
    for (int s = 0; s < NS; s++) begin
      foreach (stageSize[i]) ;
      runScan(s, 32'h0000_1000 + 32'(s) * 32'h340, 0, 0);
      runScan(s, 32'h0000_2000 + 32'(s) * 32'h200, 16, 0);
      runScan(s, 32'h0000_3000 + 32'(s) * 32'h100, 32, 0);
      runScan(s, 32'h0000_4004 + 32'(s) * 32'h40, 36, 0);
      runScan(s, 32'h0000_5008 + 32'(s) * 32'h80, 98, 0);
      runScan(s, 32'h0001_0000 + 32'(s) * 32'h1000, 128, s == 2);
    end
    imgBase = 32'h00FF_0000; smpBase = 32'h0;
    runScan(1, 32'h0000_7000, 96, 1);
    refused(2, 0, 32'h0000_9000);
    refused(3, 1, 32'h0);
    refused(6, 1, 32'h0000_9000);
    runScan(4, 32'h0000_8000, 64, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run act hung exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule